// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block merges the four interrupt causes of a 16550-class serial port into one interrupt line and one identification byte. The causes are line-status errors, receive data (trigger level or character timeout), transmitter holding empty, and modem-status change. Each cause is gated by its own bit of a 4-bit enable register. When several causes are enabled and pending together, a fixed priority picks the one that is reported. Each cause is cleared by its own register access.

The surrounding UART supplies the raw conditions: error flags, FIFO trigger and timeout indications, the transmit-empty level and the modem delta flags. It also supplies one-cycle strobes for reads of the identification, line-status, receive and modem-status registers and for writes of the transmit register. The identification byte is combinational from the held state and the level inputs. The interrupt line is registered, so it follows the byte one clock later and has no glitches.

Top module: `uart_intr_ident`

## Requirements
- R1: Enable bit 0 gates receive data, bit 1 gates transmit empty, bit 2 gates line status and bit 3 gates modem status. A latched cause whose enable bit is 0 is not reported. It stays latched and appears as soon as its enable bit is set.
- R2: Identification bit 0 is 1 when no enabled cause is pending and 0 when one is. When bit 0 is 1, bits 3:1 are 000.
- R3: Bits 2:1 carry the cause ID: 11 for line status, 10 for receive data, 01 for transmit empty and 00 for modem status. The highest of these, in that order, is reported.
- R4: A reported line-status cause reads 0x06 and a trigger-level cause reads 0x04. A pending character timeout sets bit 3 alongside ID 10 and reads 0x0C (values given with the FIFO flag clear).
- R5: Bits 7:6 both read 1 while the FIFO-enabled input is 1, and both read 0 otherwise.
- R6: A line-status cause is latched when any error input bit goes from 0 to 1. It is cleared by a line-status read. A new error in the same cycle as the read wins, and the cause stays latched.
- R7: The receive-data cause is the trigger-level input OR a timeout latch. The timeout latch is set on a 0-to-1 transition of the timeout input and cleared by a receive-buffer read. With the trigger input low and no timeout, the cause is absent.
- R8: The transmit-empty cause is latched when the empty input goes from 0 to 1. It is cleared by a transmit write, by the empty input being 0, or by an identification read in which transmit empty is the reported cause. An identification read that reports another cause leaves it latched.
- R9: A change of the FIFO-enabled input while the empty input is 1 latches the transmit-empty cause again.
- R10: A modem-status cause is latched when any delta input bit goes from 0 to 1, and it is cleared by a modem-status read.
- R11: The interrupt output equals, one clock later, the inverse of identification bit 0.
- R12: Bits 5:4 always read 0. Bit 3 reads 1 only while bits 2:0 read 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_i | input | 4 | Cause enable bits |
| fifo_en_i | input | 1 | FIFOs enabled |
| lsr_err_i | input | ERR_W (4) | Overrun, parity, framing and break flags |
| rx_trig_i | input | 1 | Receive FIFO at or above trigger level |
| rx_tmo_i | input | 1 | Character timeout condition |
| thr_empty_i | input | 1 | Transmit holding register / FIFO empty |
| msr_delta_i | input | DLT_W (4) | Modem delta flags |
| iir_rd_i | input | 1 | Identification register read strobe |
| lsr_rd_i | input | 1 | Line-status register read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| msr_rd_i | input | 1 | Modem-status register read strobe |
| thr_wr_i | input | 1 | Transmit register write strobe |
| irq_o | output | 1 | Registered interrupt request |
| iir_o | output | 8 | Identification byte |

## Verification
A wrong latch state shows up in the identification byte in the very cycle after the edge that corrupted it. If the bad latch is not masked by a higher cause, it appears as a wrong ID, a stuck or missing bit 3, or a stuck bit 0. A priority or enable error appears as a wrong ID as soon as two causes overlap. A fault in the interrupt register shows up as a mismatch between the line and the byte one clock later. The bench drives overlapping causes and clears that coincide with new events, so that masked state is brought out through the byte.

// File: rtl/uart_intr_pkg.sv
package uart_intr_pkg;
    localparam int SRC_N  = 4;
    localparam int ID_W   = $clog2(SRC_N);
    localparam int BYTE_W = 8;

    // index of each cause in the request vector equals its reported ID,
    // so a higher index means a higher priority
    typedef enum logic [ID_W-1:0] {
        SRC_MODEM  = 2'b00,
        SRC_THRE   = 2'b01,
        SRC_RXDATA = 2'b10,
        SRC_LINE   = 2'b11
    } src_id_e;

    // position of each cause in the enable register
    localparam int EN_RX    = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
endpackage

// File: rtl/uis_evt_latch.sv
// Latches a cause when any bit of a flag vector rises; a clear strobe
// drops it unless a new rise arrives in the same cycle.
module uis_evt_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vec_i,
    input  logic         clr_i,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic         pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = vec_i;
        if (|(vec_i & ~st_q.prev)) begin
            st_d.pend = 1'b1;
        end else if (clr_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/uis_thre_track.sv
// Transmit-empty event: raised on the empty level rising or on a FIFO mode
// change while empty; dropped by a write, by the level falling, or by an
// identification read that reports this cause.
module uis_thre_track (
    input  logic clk,
    input  logic rst_n,
    input  logic empty_i,
    input  logic fifo_en_i,
    input  logic wr_i,
    input  logic iir_rd_i,
    input  logic reported_i,
    output logic pend_o
);
    typedef struct packed {
        logic empty_prev;
        logic fifo_prev;
        logic pend;
    } st_t;

    st_t  st_d, st_q;
    logic raise;
    logic drop;

    always_comb begin
        raise = empty_i && (!st_q.empty_prev || (fifo_en_i != st_q.fifo_prev));
        drop  = wr_i || !empty_i || (iir_rd_i && reported_i);

        st_d            = st_q;
        st_d.empty_prev = empty_i;
        st_d.fifo_prev  = fifo_en_i;
        if (raise) begin
            st_d.pend = 1'b1;
        end else if (drop) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/uis_prio_enc.sv
// Highest-index-wins encoder over the request vector.
module uis_prio_enc #(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] id_o
);
    logic [N-1:0] above;

    // above[i] is set when a request with index greater than i is present
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_above
            if (g == N - 1) begin : g_top
                assign above[g] = 1'b0;
            end else begin : g_mid
                assign above[g] = |req_i[N-1:g+1];
            end
        end
    endgenerate

    always_comb begin
        id_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !above[i]) begin
                id_o = IW'(i);
            end
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/uart_intr_ident.sv
module uart_intr_ident
    import uart_intr_pkg::*;
#(
    parameter int ERR_W = 4,
    parameter int DLT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  ier_i,
    input  logic              fifo_en_i,
    input  logic [ERR_W-1:0]  lsr_err_i,
    input  logic              rx_trig_i,
    input  logic              rx_tmo_i,
    input  logic              thr_empty_i,
    input  logic [DLT_W-1:0]  msr_delta_i,
    input  logic              iir_rd_i,
    input  logic              lsr_rd_i,
    input  logic              rbr_rd_i,
    input  logic              msr_rd_i,
    input  logic              thr_wr_i,
    output logic              irq_o,
    output logic [BYTE_W-1:0] iir_o
);
    typedef struct packed {
        logic irq;
    } st_t;

    st_t              st_d, st_q;
    logic             line_pend;
    logic             modem_pend;
    logic             tmo_pend;
    logic             thre_pend;
    logic [SRC_N-1:0] req;
    logic             any_req;
    logic [ID_W-1:0]  win_id;
    logic             thre_shown;

    uis_evt_latch #(.W(ERR_W)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .vec_i  (lsr_err_i),
        .clr_i  (lsr_rd_i),
        .pend_o (line_pend)
    );

    uis_evt_latch #(.W(DLT_W)) u_modem (
        .clk    (clk),
        .rst_n  (rst_n),
        .vec_i  (msr_delta_i),
        .clr_i  (msr_rd_i),
        .pend_o (modem_pend)
    );

    uis_evt_latch #(.W(1)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .vec_i  (rx_tmo_i),
        .clr_i  (rbr_rd_i),
        .pend_o (tmo_pend)
    );

    uis_thre_track u_thre (
        .clk        (clk),
        .rst_n      (rst_n),
        .empty_i    (thr_empty_i),
        .fifo_en_i  (fifo_en_i),
        .wr_i       (thr_wr_i),
        .iir_rd_i   (iir_rd_i),
        .reported_i (thre_shown),
        .pend_o     (thre_pend)
    );

    always_comb begin
        req             = '0;
        req[SRC_LINE]   = ier_i[EN_LINE]  && line_pend;
        req[SRC_RXDATA] = ier_i[EN_RX]    && (rx_trig_i || tmo_pend);
        req[SRC_THRE]   = ier_i[EN_THRE]  && thre_pend;
        req[SRC_MODEM]  = ier_i[EN_MODEM] && modem_pend;
    end

    uis_prio_enc #(.N(SRC_N)) u_prio (
        .req_i (req),
        .any_o (any_req),
        .id_o  (win_id)
    );

    assign thre_shown = any_req && (win_id == SRC_THRE);

    always_comb begin
        iir_o      = '0;
        iir_o[0]   = !any_req;
        iir_o[2:1] = any_req ? win_id : '0;
        iir_o[3]   = any_req && (win_id == SRC_RXDATA) && tmo_pend;
        iir_o[7:6] = {2{fifo_en_i}};
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = any_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/uart_intr_ident_chk.sv
module uart_intr_ident_chk #(
    parameter int ERR_W = 4,
    parameter int DLT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en_i,
    input logic [ERR_W-1:0] lsr_err_i,
    input logic             thr_empty_i,
    input logic [DLT_W-1:0] msr_delta_i,
    input logic             lsr_rd_i,
    input logic             msr_rd_i,
    input logic             thr_wr_i,
    input logic             irq_o,
    input logic [7:0]       iir_o
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    p_idle_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iir_o[0] |-> (iir_o[3:1] == 3'b000));

    p_tmo_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_o[5:4] == 2'b00) && (iir_o[3] -> (iir_o[2:0] == 3'b100)));

    p_irq_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (irq_o == !$past(iir_o[0])));

    p_line_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && lsr_rd_i && ((lsr_err_i & ~$past(lsr_err_i)) == '0))
        |=> (iir_o[2:0] != 3'b110));

    p_modem_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && msr_rd_i && ((msr_delta_i & ~$past(msr_delta_i)) == '0))
        |=> (iir_o[2:0] != 3'b000));

    p_thre_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && thr_wr_i && !(thr_empty_i && !$past(thr_empty_i))
         && (fifo_en_i == $past(fifo_en_i)))
        |=> (iir_o[2:0] != 3'b010));
endmodule

bind uart_intr_ident uart_intr_ident_chk #(.ERR_W(ERR_W), .DLT_W(DLT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en_i   (fifo_en_i),
    .lsr_err_i   (lsr_err_i),
    .thr_empty_i (thr_empty_i),
    .msr_delta_i (msr_delta_i),
    .lsr_rd_i    (lsr_rd_i),
    .msr_rd_i    (msr_rd_i),
    .thr_wr_i    (thr_wr_i),
    .irq_o       (irq_o),
    .iir_o       (iir_o)
);

// File: tb/uart_intr_ident_tb_top.sv
`timescale 1ns/1ps
module uart_intr_ident_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ier = '0;
    logic       fifo_en = 1'b0;
    logic [3:0] err = '0;
    logic       rx_trig = 1'b0;
    logic       rx_tmo = 1'b0;
    logic       empty = 1'b0;
    logic [3:0] delta = '0;
    logic       iir_rd = 1'b0, lsr_rd = 1'b0, rbr_rd = 1'b0, msr_rd = 1'b0, thr_wr = 1'b0;
    logic       irq;
    logic [7:0] iir;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_intr_ident dut_i (
        .clk(clk), .rst_n(rst_n), .ier_i(ier), .fifo_en_i(fifo_en),
        .lsr_err_i(err), .rx_trig_i(rx_trig), .rx_tmo_i(rx_tmo),
        .thr_empty_i(empty), .msr_delta_i(delta), .iir_rd_i(iir_rd),
        .lsr_rd_i(lsr_rd), .rbr_rd_i(rbr_rd), .msr_rd_i(msr_rd),
        .thr_wr_i(thr_wr), .irq_o(irq), .iir_o(iir)
    );

    // behavioural reference state
    bit       m_ls, m_ms, m_tmo, m_thr, m_irq;
    bit [3:0] p_err, p_delta;
    bit       p_tmo, p_empty, p_fifo;

    function automatic logic [7:0] model_iir();
        logic [7:0] v;
        if (ier[2] && m_ls)                    v = 8'h06;
        else if (ier[0] && (rx_trig || m_tmo)) v = m_tmo ? 8'h0C : 8'h04;
        else if (ier[1] && m_thr)              v = 8'h02;
        else if (ier[3] && m_ms)               v = 8'h00;
        else                                   v = 8'h01;
        v[7:6] = {2{fifo_en}};
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ls = 0; m_ms = 0; m_tmo = 0; m_thr = 0; m_irq = 0;
            p_err = 0; p_delta = 0; p_tmo = 0; p_empty = 0; p_fifo = 0;
        end else begin
            logic [7:0] now;
            bit rep_thr;
            now     = model_iir();
            rep_thr = (now[0] == 1'b0) && (now[2:1] == 2'b01);
            m_irq   = !now[0];
            if ((err & ~p_err) != 0) m_ls = 1; else if (lsr_rd) m_ls = 0;
            if ((delta & ~p_delta) != 0) m_ms = 1; else if (msr_rd) m_ms = 0;
            if (rx_tmo && !p_tmo) m_tmo = 1; else if (rbr_rd) m_tmo = 0;
            if (empty && (!p_empty || fifo_en != p_fifo)) m_thr = 1;
            else if (thr_wr || !empty || (iir_rd && rep_thr)) m_thr = 0;
            p_err = err; p_delta = delta; p_tmo = rx_tmo; p_empty = empty; p_fifo = fifo_en;
        end
    end

    // cycle-by-cycle comparison, before the bench moves any input
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (iir !== model_iir()) begin
                fails++;
                $display("FAIL R3 model iir: actual %h expected %h", iir, model_iir());
            end
            tests++;
            if (irq !== m_irq) begin
                fails++;
                $display("FAIL R11 model irq: actual %b expected %b", irq, m_irq);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic clr_strobes();
        iir_rd = 0; lsr_rd = 0; rbr_rd = 0; msr_rd = 0; thr_wr = 0;
        err = 0; delta = 0; rx_tmo = 0;
    endtask

    task automatic chk_iir(input logic [7:0] exp, input string req);
        tests++;
        if (iir !== exp) begin
            fails++;
            $display("FAIL %s iir: actual %h expected %h", req, iir, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string req);
        tests++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq: actual %b expected %b", req, irq, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1;
        cyc();
        chk_iir(8'h01, "R2 reset"); chk_irq(1'b0, "R2 reset");

        // R1: disabled cause is held but not shown
        err = 4'b0001; cyc(); clr_strobes(); cyc(); cyc();
        chk_iir(8'h01, "R1 gated"); chk_irq(1'b0, "R1 gated");
        ier = 4'b0100; cyc();
        chk_iir(8'h06, "R1 enable late");
        lsr_rd = 1; cyc(); clr_strobes();
        chk_iir(8'h01, "R6 clear");
        chk_irq(1'b1, "R11 lag");
        cyc();
        chk_irq(1'b0, "R11 lag drop");

        // R3 / R4 / R7
        ier = 4'hF; rx_trig = 1; err = 4'b0010; cyc(); clr_strobes();
        chk_iir(8'h06, "R3 line over rx");
        lsr_rd = 1; cyc(); clr_strobes();
        chk_iir(8'h04, "R4 trigger");
        rx_trig = 0; cyc();
        chk_iir(8'h01, "R7 level");
        rx_tmo = 1; cyc(); clr_strobes();
        chk_iir(8'h0C, "R4 R12 timeout");
        rbr_rd = 1; cyc(); clr_strobes();
        chk_iir(8'h01, "R7 timeout clear");

        // R8 / R10
        empty = 1; cyc();
        chk_iir(8'h02, "R8 raise");
        delta = 4'b0100; cyc(); clr_strobes();
        chk_iir(8'h02, "R3 thre over modem");
        iir_rd = 1; cyc(); clr_strobes();
        chk_iir(8'h00, "R8 iir read R10 modem");
        msr_rd = 1; cyc(); clr_strobes();
        chk_iir(8'h01, "R10 clear");
        empty = 0; cyc(); empty = 1; cyc();
        chk_iir(8'h02, "R8 re-raise");
        err = 4'b0100; cyc(); clr_strobes();
        chk_iir(8'h06, "R3 line over thre");
        iir_rd = 1; cyc(); clr_strobes();
        chk_iir(8'h06, "R8 read of other cause");
        lsr_rd = 1; cyc(); clr_strobes();
        chk_iir(8'h02, "R8 survived read");
        thr_wr = 1; cyc(); clr_strobes();
        chk_iir(8'h01, "R8 write clear");

        // R9 / R5
        fifo_en = 1; cyc();
        chk_iir(8'hC2, "R9 R5 fifo on");
        thr_wr = 1; cyc(); clr_strobes();
        chk_iir(8'hC1, "R5 idle fifo");
        fifo_en = 0; cyc();
        chk_iir(8'h02, "R9 fifo off");
        thr_wr = 1; cyc(); clr_strobes();
        chk_iir(8'h01, "R8 write clear 2");

        // R6 new error beats simultaneous read
        err = 4'b1000; lsr_rd = 1; cyc(); clr_strobes();
        chk_iir(8'h06, "R6 set wins");
        lsr_rd = 1; cyc(); clr_strobes();
        chk_iir(8'h01, "R6 clear 2");

        // R10 / R1 modem held while disabled
        ier = 4'b0111; delta = 4'b0001; cyc(); clr_strobes();
        chk_iir(8'h01, "R1 modem gated");
        ier = 4'hF; cyc();
        chk_iir(8'h00, "R10 modem held");
        chk_irq(1'b1, "R11 modem");
        msr_rd = 1; cyc(); clr_strobes();
        chk_iir(8'h01, "R10 clear 2");
        cyc();
        chk_irq(1'b0, "R11 idle");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule